// File: doc/BRIEF.md
# Offset-Rotated Byte-Lane Scatter Datapath

This datapath prepares one write to a bank of 64 byte-wide slots. The caller supplies a 128-bit word of sixteen byte lanes, a 16-bit enable mask naming the lanes to be written, and a 6-bit base slot. Lane i is aimed at slot (base + i) mod 64. The block produces a 64-bit strobe vector, one bit per slot, and a 512-bit vector that holds one data byte per slot. A byte array next to the block can then update every slot from its own strobe and byte, with no address decoding.

Two barrel rotators replace sixteen separate address decoders. Each rotator is a chain of six 2:1 mux stages, one stage per base bit. The first rotator turns the zero-extended mask into slot strobes. The second turns the zero-extended lane data into slot bytes. A gating stage then forces to zero the byte of every slot whose strobe is clear. The mask may hold any pattern. Sixteen consecutive slots modulo 64 never overlap, so no priority logic is needed.

A parameter selects the output timing. The outputs are either purely combinational, or they pass through one register stage with a synchronous active-high reset.

Top module: `scatter_datapath`

## Requirements
- R1: The byte of lane i, at input bits 8i+7..8i, appears on output byte s = (base + i) mod 64, at bits 8s+7..8s, whenever mask bit i is set.
- R2: Strobe bit (base + i) mod 64 is 1 exactly when mask bit i is 1. Every other strobe bit is 0.
- R3: Slot arithmetic wraps modulo 64. With base 60, lanes 4 to 15 land on slots 0 to 11.
- R4: Any mask pattern is accepted, including all ones and more than one bit set. The number of set strobe bits equals the number of set mask bits.
- R5: A zero mask gives all strobes 0 and all output bytes 0, for any data and base.
- R6: Every slot whose strobe is 0 outputs a data byte of 0x00.
- R7: In the registered variant (REGISTER_OUT=1, the default), a clock edge with rst high clears all strobes and all data bytes to zero.
- R8: In the registered variant, the outputs show the inputs sampled at the previous rising edge. In the combinational variant (REGISTER_OUT=0), the outputs follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| lane_data_i | input | 128 | Sixteen byte lanes; lane i at bits 8i+7..8i |
| lane_en_i | input | 16 | Per-lane write enable, any pattern |
| base_slot_i | input | 6 | Slot that receives lane 0 |
| slot_we_o | output | 64 | Per-slot write strobe |
| slot_byte_o | output | 512 | Per-slot data byte; slot s at bits 8s+7..8s |

## Verification
All 64 base values are swept, each with six mask patterns: all ones, zero, a single lane, and three random masks with random data. All ones at high bases shows that wrap-around splits the run correctly across slot 63 and slot 0. The zero mask shows that nothing leaks onto the outputs. A single lane pins down the placement of one rotation amount at a time. Random masks with random data catch lanes swapped with each other and stale bytes left on unstrobed slots. A combinational instance and a registered instance see the same stimulus, which separates the two latencies, and reset is applied both at start-up and with busy inputs.

// File: rtl/scatter_pkg.sv
package scatter_pkg;
    localparam int LANES_DEF  = 16;
    localparam int SLOTS_DEF  = 64;
    localparam int BYTE_W_DEF = 8;
endpackage

// File: rtl/scatter_rotl.sv
// Left rotation of ELEMS elements of EW bits each by amt elements,
// built as one 2:1 mux stage per amount bit.
module scatter_rotl #(
    parameter int ELEMS = 64,
    parameter int EW    = 8,
    parameter int AMT_W = $clog2(ELEMS)
) (
    input  logic [ELEMS*EW-1:0] din,
    input  logic [AMT_W-1:0]    amt,
    output logic [ELEMS*EW-1:0] dout
);
    localparam int TOT = ELEMS * EW;

    logic [TOT-1:0] stage [0:AMT_W];

    assign stage[0] = din;

    generate
        for (genvar k = 0; k < AMT_W; k++) begin : g_stage
            localparam int SH = (1 << k) * EW;
            assign stage[k+1] = amt[k] ? {stage[k][TOT-SH-1:0], stage[k][TOT-1:TOT-SH]}
                                       : stage[k];
        end
    endgenerate

    assign dout = stage[AMT_W];
endmodule

// File: rtl/scatter_slot_gate.sv
// Forces the byte of every unstrobed slot to zero.
module scatter_slot_gate #(
    parameter int SLOTS  = 64,
    parameter int BYTE_W = 8
) (
    input  logic [SLOTS-1:0]        we,
    input  logic [SLOTS*BYTE_W-1:0] raw,
    output logic [SLOTS*BYTE_W-1:0] gated
);
    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            assign gated[s*BYTE_W +: BYTE_W] = raw[s*BYTE_W +: BYTE_W] & {BYTE_W{we[s]}};
        end
    endgenerate
endmodule

// File: rtl/scatter_datapath.sv
module scatter_datapath
    import scatter_pkg::*;
#(
    parameter int LANES        = LANES_DEF,
    parameter int SLOTS        = SLOTS_DEF,
    parameter int BYTE_W       = BYTE_W_DEF,
    parameter bit REGISTER_OUT = 1'b1,
    parameter int OFF_W        = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES*BYTE_W-1:0] lane_data_i,
    input  logic [LANES-1:0]        lane_en_i,
    input  logic [OFF_W-1:0]        base_slot_i,
    output logic [SLOTS-1:0]        slot_we_o,
    output logic [SLOTS*BYTE_W-1:0] slot_byte_o
);
    localparam int DATA_W = SLOTS * BYTE_W;
    localparam int PAD_B  = (SLOTS - LANES) * BYTE_W;

    logic [SLOTS-1:0]  mask_wide;
    logic [DATA_W-1:0] data_wide;
    logic [SLOTS-1:0]  we_rot;
    logic [DATA_W-1:0] data_rot;
    logic [DATA_W-1:0] data_gated;

    assign mask_wide = {{(SLOTS - LANES){1'b0}}, lane_en_i};
    assign data_wide = {{PAD_B{1'b0}}, lane_data_i};

    scatter_rotl #(.ELEMS(SLOTS), .EW(1), .AMT_W(OFF_W)) u_we_rot (
        .din  (mask_wide),
        .amt  (base_slot_i),
        .dout (we_rot)
    );

    scatter_rotl #(.ELEMS(SLOTS), .EW(BYTE_W), .AMT_W(OFF_W)) u_data_rot (
        .din  (data_wide),
        .amt  (base_slot_i),
        .dout (data_rot)
    );

    scatter_slot_gate #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_gate (
        .we    (we_rot),
        .raw   (data_rot),
        .gated (data_gated)
    );

    generate
        if (REGISTER_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_we_o   <= '0;
                    slot_byte_o <= '0;
                end else begin
                    slot_we_o   <= we_rot;
                    slot_byte_o <= data_gated;
                end
            end
        end else begin : g_comb
            always_comb begin
                slot_we_o   = we_rot;
                slot_byte_o = data_gated;
            end
        end
    endgenerate
endmodule

// File: rtl/scatter_datapath_chk.sv
module scatter_datapath_chk #(
    parameter int LANES        = 16,
    parameter int SLOTS        = 64,
    parameter int BYTE_W       = 8,
    parameter bit REGISTER_OUT = 1'b1,
    parameter int OFF_W        = 6
) (
    input logic                    clk,
    input logic                    rst,
    input logic [LANES*BYTE_W-1:0] lane_data_i,
    input logic [LANES-1:0]        lane_en_i,
    input logic [OFF_W-1:0]        base_slot_i,
    input logic [SLOTS-1:0]        slot_we_o,
    input logic [SLOTS*BYTE_W-1:0] slot_byte_o
);
    logic [LANES-1:0]  mask_seen;
    logic [BYTE_W-1:0] lane0_seen;
    logic [OFF_W-1:0]  off_seen;
    logic              leak;

    generate
        if (REGISTER_OUT) begin : g_r
            logic [LANES-1:0]  mask_q;
            logic [BYTE_W-1:0] lane0_q;
            logic [OFF_W-1:0]  off_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    mask_q  <= '0;
                    lane0_q <= '0;
                    off_q   <= '0;
                end else begin
                    mask_q  <= lane_en_i;
                    lane0_q <= lane_data_i[BYTE_W-1:0];
                    off_q   <= base_slot_i;
                end
            end
            assign mask_seen  = mask_q;
            assign lane0_seen = lane0_q;
            assign off_seen   = off_q;

            AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (slot_we_o == '0 && slot_byte_o == '0)); // R7
        end else begin : g_c
            assign mask_seen  = lane_en_i;
            assign lane0_seen = lane_data_i[BYTE_W-1:0];
            assign off_seen   = base_slot_i;
        end
    endgenerate

    always_comb begin
        leak = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (!slot_we_o[s] && slot_byte_o[s*BYTE_W +: BYTE_W] != '0) leak = 1'b1;
        end
    end

    AST_STROBE_COUNT: assert property (@(posedge clk) disable iff (rst)
        $countones(slot_we_o) == $countones(mask_seen)); // R4
    AST_NO_LEAK: assert property (@(posedge clk) disable iff (rst) !leak); // R6
    AST_LANE0_STROBE: assert property (@(posedge clk) disable iff (rst)
        mask_seen[0] |-> slot_we_o[off_seen]); // R2
    AST_LANE0_BYTE: assert property (@(posedge clk) disable iff (rst)
        mask_seen[0] |-> (slot_byte_o[off_seen*BYTE_W +: BYTE_W] == lane0_seen)); // R1
    AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask_seen == '0) |-> (slot_we_o == '0)); // R5
endmodule

bind scatter_datapath scatter_datapath_chk #(
    .LANES(LANES), .SLOTS(SLOTS), .BYTE_W(BYTE_W),
    .REGISTER_OUT(REGISTER_OUT), .OFF_W(OFF_W)
) chk_i (
    .clk(clk), .rst(rst), .lane_data_i(lane_data_i), .lane_en_i(lane_en_i),
    .base_slot_i(base_slot_i), .slot_we_o(slot_we_o), .slot_byte_o(slot_byte_o)
);

// File: tb/scatter_datapath_tb_top.sv
`timescale 1ns/1ps
module scatter_datapath_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] lane_data;
    logic [15:0]  lane_en;
    logic [5:0]   base;
    logic [63:0]  we_r, we_c;
    logic [511:0] byte_r, byte_c;
    logic [63:0]  exp_we;
    logic [511:0] exp_byte;
    int           n_tests = 0;
    int           n_fail  = 0;
    bit           done    = 1'b0;

    always #5 clk = ~clk;

    scatter_datapath #(.REGISTER_OUT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .lane_data_i(lane_data), .lane_en_i(lane_en),
        .base_slot_i(base), .slot_we_o(we_r), .slot_byte_o(byte_r)
    );

    scatter_datapath #(.REGISTER_OUT(1'b0)) dut_c (
        .clk(clk), .rst(rst), .lane_data_i(lane_data), .lane_en_i(lane_en),
        .base_slot_i(base), .slot_we_o(we_c), .slot_byte_o(byte_c)
    );

    task automatic build_ref();
        exp_we   = '0;
        exp_byte = '0;
        for (int i = 0; i < 16; i++) begin
            if (lane_en[i]) begin
                int s;
                s = (int'(base) + i) % 64;
                exp_we[s] = 1'b1;
                exp_byte[s*8 +: 8] = lane_data[i*8 +: 8];
            end
        end
    endtask

    task automatic chk_we(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s base=%0d mask=%h strobe act=%h exp=%h", req, base, lane_en, act, exp);
        end
    endtask

    task automatic chk_byte(string req, logic [511:0] act, logic [511:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s base=%0d mask=%h data act=%h exp=%h", req, base, lane_en, act, exp);
        end
    endtask

    task automatic apply(logic [15:0] m, logic [5:0] b, logic [127:0] d);
        string rq;
        @(negedge clk);
        lane_en = m; base = b; lane_data = d;
        build_ref();
        if (m == 16'h0)                   rq = "R5";
        else if (int'(b) + 15 >= 64)      rq = "R3";
        else if (m == 16'hffff)           rq = "R4";
        else                              rq = "R2";
        #1;
        chk_we({rq, "/R8 comb"}, we_c, exp_we);
        chk_byte("R1/R6/R8 comb", byte_c, exp_byte);
        @(negedge clk);
        chk_we({rq, "/R8 reg"}, we_r, exp_we);
        chk_byte("R1/R6/R8 reg", byte_r, exp_byte);
    endtask

    function automatic logic [127:0] rnd_data();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        lane_en = 16'hffff; base = 6'd3; lane_data = rnd_data();
        @(negedge clk); @(negedge clk);
        chk_we("R7 reset", we_r, '0);
        chk_byte("R7 reset", byte_r, '0);
        rst = 1'b0;

        for (int b = 0; b < 64; b++) begin
            apply(16'hffff, 6'(b), rnd_data());
            apply(16'h0000, 6'(b), rnd_data());
            apply(16'h1 << (b % 16), 6'(b), rnd_data());
            for (int r = 0; r < 3; r++) apply(16'($urandom()), 6'(b), rnd_data());
        end

        apply(16'hffff, 6'd60, 128'h0f0e0d0c0b0a09080706050403020100);

        @(negedge clk);
        rst = 1'b1; lane_en = 16'hffff; base = 6'd17; lane_data = rnd_data();
        @(negedge clk);
        chk_we("R7 mid-run reset", we_r, '0);
        chk_byte("R7 mid-run reset", byte_r, '0);
        rst = 1'b0;
        apply(16'ha5c3, 6'd63, rnd_data());

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired act=hung exp=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule